// File: doc/BRIEF.md
# Falling-Edge Event Counter Bank

This block keeps a bank of free-running event counters, one fixed to each digital input line. Every input passes through a short synchronizer chain. Each falling edge seen on the synchronized level advances that input's counter by one. The counters only ever move forward and wrap to zero; software cannot clear them, and only power-on reset sets them to zero.

A host reads the block through a register select and a read strobe. When the strobe rises, the selected word is copied into a holding register. The data port then shows that frozen copy for as long as the strobe stays high, even while the live counters keep moving. The slot after the last counter is a digital I/O word. It shows the synchronized input levels, and it holds one host-writable output bit that drives an output pin. Falling edges on input 0 also leave the block as a one-cycle acquisition trigger pulse.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset, every counter reads zero, the output pin is low, the trigger is low and the read data port is zero.
- R2: Each falling edge on an input that lasts at least one clock cycle advances only that input's counter, by exactly one. Rising edges are not counted. The count becomes visible on the third rising clock edge after the input falls.
- R3: A counter holding its all-ones value (0xFFFF at the default 16-bit width) goes to zero on the next edge.
- R4: A write to a counter slot (select values 0 to 3) has no effect on any count.
- R5: The read data port changes only on the clock edge where the read strobe is first seen high. While the strobe stays high, the value does not change.
- R6: A falling edge that is counted on the same clock edge as a capture is not in that captured value. It appears in the next read.
- R7: The I/O word at select value 4 returns the four synchronized input levels in bits 3:0, with input n in bit n. Bit 4 holds the output bit, and bits 15:5 read as zero.
- R8: A write strobe with select value 4 loads write-data bit 4 into the output bit, which drives the output pin from the next clock edge. Writes to any other slot leave the output bit unchanged.
- R9: Every counted falling edge on input 0 produces exactly one single-cycle pulse on the trigger output. No pulse is ever two cycles long.
- R10: Select values 0 to 3 return counters 0 to 3 in that order, zero-extended to the bus width. Select values 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| pin_in | input | 4 | Asynchronous digital inputs, one per counter |
| rd_strobe | input | 1 | Host read strobe; capture happens on its first high cycle |
| rd_sel | input | 3 | Register slot selected for reading |
| rd_data | output | 16 | Captured read word |
| wr_strobe | input | 1 | Host write strobe, one cycle per write |
| wr_sel | input | 3 | Register slot selected for writing |
| wr_data | input | 16 | Write word; only bit 4 in slot 4 is used |
| out_pin | output | 1 | Host-controlled digital output |
| trig_out | output | 1 | One-cycle pulse per counted falling edge of input 0 |

## Verification
The hardest case to reach is an edge that lands in the same clock cycle as a capture. To get it, the bench drives input 0 low and waits two falling clock edges. It then raises the read strobe, so the capture and the increment share the following rising edge. With the strobe still held, further pulses check that the frozen word stays put. The counters are instantiated 8 bits wide, so wrap-around can be swept completely, and a pseudo-random run over all four inputs at once checks the counts against a per-input model.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

   // smallest synchronizer chain accepted by the bank
   localparam int unsigned SYNC_MIN = 2;

   // number of register slots: one per counter plus the I/O word
   function automatic int unsigned slot_count(input int unsigned n_in);
      return n_in + 1;
   endfunction

   // select width needed to address every slot
   function automatic int unsigned sel_bits_needed(input int unsigned n_in);
      return $clog2(slot_count(n_in));
   endfunction

endpackage

// File: rtl/evt_sync_fall.sv
module evt_sync_fall #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < evt_cnt_pkg::SYNC_MIN) begin : g_bad_stages
         $error("evt_sync_fall: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign fall  = prev_q & ~chain_q[STAGES-1];

   // R9: a detected fall is never two cycles long
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/evt_wrap_counter.sv
module evt_wrap_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_width
         $error("evt_wrap_counter: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + W'(1);
   end

   assign value = cnt_q;

   // R2: each event moves the count by exactly one
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> value == W'($past(value) + W'(1)));

   // R3: all-ones wraps to zero
   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && (&value)) |=> value == '0);

   // R4: without an event nothing moves the count
   a_r4_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(value));

endmodule

// File: rtl/evt_read_capture.sv
module evt_read_capture #(
   parameter int unsigned NUM   = 4,
   parameter int unsigned CW    = 16,
   parameter int unsigned BW    = 16,
   parameter int unsigned SW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic [SW-1:0]     rd_sel,
   input  logic [NUM*CW-1:0] cnt_flat,
   input  logic [BW-1:0]     io_word,
   output logic [BW-1:0]     rd_data
);
   localparam int unsigned SLOTS = evt_cnt_pkg::slot_count(NUM);

   logic [BW-1:0] slot_word [SLOTS];
   logic [BW-1:0] sel_word;
   logic [BW-1:0] hold_q;
   logic          rd_q;
   logic          cap;

   genvar gi;
   generate
      for (gi = 0; gi < NUM; gi++) begin : g_slot
         if (CW == BW) begin : g_full
            assign slot_word[gi] = cnt_flat[gi*CW +: CW];
         end else begin : g_ext
            assign slot_word[gi] = {{(BW-CW){1'b0}}, cnt_flat[gi*CW +: CW]};
         end
      end
   endgenerate
   assign slot_word[NUM] = io_word;

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (rd_sel == SW'(i)) sel_word = slot_word[i];
      end
   end

   assign cap = rd_strobe & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         hold_q <= '0;
      end else begin
         rd_q <= rd_strobe;
         if (cap) hold_q <= sel_word;
      end
   end

   assign rd_data = hold_q;

   // R5: a held strobe keeps the captured word frozen
   a_r5_hold_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && rd_q) |=> $stable(rd_data));

   // R5: without a strobe the captured word stays put
   a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data));

endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank #(
   parameter int unsigned NUM_IN      = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pin_in,
   input  logic              rd_strobe,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              wr_strobe,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BUS_W-1:0]  wr_data,
   output logic              out_pin,
   output logic              trig_out
);
   localparam int unsigned IO_SLOT = NUM_IN;
   localparam int unsigned OUT_BIT = NUM_IN;

   generate
      if (NUM_IN < 1 || NUM_IN + 1 > BUS_W) begin : g_bad_num
         $error("evt_cnt_bank: NUM_IN does not fit the bus");
      end
      if (CNT_W > BUS_W) begin : g_bad_cnt
         $error("evt_cnt_bank: CNT_W wider than BUS_W");
      end
      if (SEL_W < evt_cnt_pkg::sel_bits_needed(NUM_IN)) begin : g_bad_sel
         $error("evt_cnt_bank: SEL_W too narrow for all slots");
      end
   endgenerate

   logic [NUM_IN-1:0]       level;
   logic [NUM_IN-1:0]       fall;
   logic [NUM_IN*CNT_W-1:0] cnt_flat;
   logic [BUS_W-1:0]        io_word;
   logic                    out_q;
   logic                    io_wr;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IN; gi++) begin : g_lane
         evt_sync_fall #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[gi]),
            .level (level[gi]),
            .fall  (fall[gi])
         );
         evt_wrap_counter #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (fall[gi]),
            .value (cnt_flat[gi*CNT_W +: CNT_W])
         );
      end
   endgenerate

   assign io_wr = wr_strobe && (wr_sel == SEL_W'(IO_SLOT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= 1'b0;
      else if (io_wr) out_q <= wr_data[OUT_BIT];
   end

   generate
      if (BUS_W > NUM_IN + 1) begin : g_io_pad
         assign io_word = {{(BUS_W-NUM_IN-1){1'b0}}, out_q, level};
      end else begin : g_io_tight
         assign io_word = {out_q, level};
      end
   endgenerate

   evt_read_capture #(
      .NUM (NUM_IN),
      .CW  (CNT_W),
      .BW  (BUS_W),
      .SW  (SEL_W)
   ) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_strobe (rd_strobe),
      .rd_sel    (rd_sel),
      .cnt_flat  (cnt_flat),
      .io_word   (io_word),
      .rd_data   (rd_data)
   );

   assign out_pin  = out_q;
   assign trig_out = fall[0];

   // R8: a write to the I/O slot loads the output bit
   a_r8_out_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && wr_sel == SEL_W'(IO_SLOT)) |=> out_pin == $past(wr_data[OUT_BIT]));

   // R8: other slots leave the output bit alone
   a_r8_out_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_strobe && wr_sel == SEL_W'(IO_SLOT)) |=> $stable(out_pin));

endmodule

// File: tb/test_evt_cnt_bank.sv
module test_evt_cnt_bank;
   localparam int unsigned NI = 4;
   localparam int unsigned CW = 8;
   localparam int unsigned MODV = 1 << CW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_in = 4'hF;
   logic        rd_strobe = 1'b0;
   logic [2:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        wr_strobe = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        out_pin;
   logic        trig_out;

   int checks = 0;
   int fails = 0;
   int unsigned mcnt [NI];
   logic [3:0]  pins_cur = 4'hF;
   logic        out_m = 1'b0;
   int unsigned trig_exp = 0;
   int unsigned trig_seen = 0;

   always #5 clk = ~clk;

   evt_cnt_bank #(.NUM_IN(NI), .CNT_W(CW), .BUS_W(16), .SEL_W(3)) i_evt_cnt_bank (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rd_strobe(rd_strobe), .rd_sel(rd_sel),
      .rd_data(rd_data), .wr_strobe(wr_strobe), .wr_sel(wr_sel), .wr_data(wr_data),
      .out_pin(out_pin), .trig_out(trig_out));

   always @(negedge clk) if (rst_n && trig_out) trig_seen++;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] nv);
      for (int i = 0; i < NI; i++) begin
         if (pins_cur[i] && !nv[i]) begin
            mcnt[i] = (mcnt[i] + 1) % MODV;
            if (i == 0) trig_exp++;
         end
      end
      pins_cur = nv;
      pin_in = nv;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] sel, output logic [15:0] val);
      rd_sel = sel;
      rd_strobe = 1'b1;
      @(negedge clk);
      val = rd_data;
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      wr_sel = sel;
      wr_data = d;
      wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
   endtask

   task automatic check_all(input string tag);
      logic [15:0] v;
      for (int i = 0; i < NI; i++) begin
         rd(3'(i), v);
         check(tag, v, 16'(mcnt[i]));
      end
   endtask

   task automatic pulse(input int idx);
      logic [3:0] lo;
      lo = pins_cur;
      lo[idx] = 1'b0;
      apply(lo);
      apply(lo);
      lo[idx] = 1'b1;
      apply(lo);
      apply(lo);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [15:0] v;
      logic [15:0] old;
      logic [15:0] lfsr;
      for (int i = 0; i < NI; i++) mcnt[i] = 0;
      repeat (4) @(negedge clk);
      check("R1 data", rd_data, 16'h0);
      check("R1 out", {15'b0, out_pin}, 16'h0);
      check("R1 trig", {15'b0, trig_out}, 16'h0);
      rst_n = 1'b1;
      settle();
      check_all("R1 counters");

      // R2 / R10: per-input sweeps, each input a different count
      for (int i = 0; i < NI; i++) begin
         for (int k = 0; k < 20 * (i + 1) + 3; k++) pulse(i);
         settle();
         check_all("R2 R10 per-input");
      end
      // rising edge alone
      apply(pins_cur & 4'b1101);
      settle();
      apply(pins_cur | 4'b0010);
      settle();
      check_all("R2 rise ignored");

      // R3: walk counter 1 to all-ones then wrap
      while (mcnt[1] != MODV - 1) pulse(1);
      settle();
      rd(3'd1, v);
      check("R3 all ones", v, 16'(MODV - 1));
      pulse(1);
      settle();
      rd(3'd1, v);
      check("R3 wrap zero", v, 16'h0);
      for (int k = 0; k < 300; k++) pulse(3);
      settle();
      check_all("R3 long wrap");

      // R4: writes to counter slots ignored
      for (int i = 0; i < NI; i++) wr(3'(i), 16'hFFFF);
      for (int i = 0; i < NI; i++) wr(3'(i), 16'h0000);
      settle();
      check_all("R4 no clear");
      check("R4 R8 out untouched", {15'b0, out_pin}, 16'h0);

      // R8 / R7
      wr(3'd4, 16'h0010);
      out_m = 1'b1;
      check("R8 out set", {15'b0, out_pin}, 16'h1);
      rd(3'd4, v);
      check("R7 io word", v, {11'b0, out_m, pins_cur});
      wr(3'd4, 16'hFFEF);
      out_m = 1'b0;
      check("R8 out clear", {15'b0, out_pin}, 16'h0);
      wr(3'd4, 16'h0010);
      out_m = 1'b1;
      for (int p = 0; p < 16; p++) begin
         apply(4'(p));
         settle();
         rd(3'd4, v);
         check("R7 io sweep", v, {11'b0, out_m, 4'(p)});
      end
      apply(4'hF);
      settle();
      check_all("R2 after io sweep");
      for (int s = 5; s < 8; s++) begin
         rd(3'(s), v);
         check("R10 unmapped zero", v, 16'h0);
      end

      // R6 / R5: edge lands on the capture edge
      old = 16'(mcnt[0]);
      pin_in[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rd_sel = 3'd0;
      rd_strobe = 1'b1;
      pin_in[0] = 1'b1;
      mcnt[0] = (mcnt[0] + 1) % MODV;
      trig_exp++;
      @(negedge clk);
      check("R6 coincident edge excluded", rd_data, old);
      for (int k = 0; k < 3; k++) pulse(0);
      settle();
      check("R5 frozen while strobe high", rd_data, old);
      rd_strobe = 1'b0;
      @(negedge clk);
      rd(3'd0, v);
      check("R6 edge in next read", v, 16'(mcnt[0]));

      // mixed pseudo-random activity on all inputs
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         apply(lfsr[3:0]);
         if (k % 500 == 499) begin
            settle();
            check_all("R2 random mix");
         end
      end
      apply(4'hF);
      settle();
      check_all("R2 random end");

      check("R9 trigger pulses", 16'(trig_seen), 16'(trig_exp));
      summary();
   end
endmodule